// File: doc/BRIEF.md
# High-Side Switch Fault Controller

This block supervises the enable of a high-side switch that feeds a bus pull-up. It watches a digital over-current comparator flag, a temperature flag that already carries its own hysteresis, a bus-healthy indication that goes high once a short is gone, and a single-cycle clear strobe from the register file. From these it decides each cycle whether the switch conducts, and whether it conducts at the reduced current level.

A two-bit profile input selects how an over-current is handled: hold the switch on at a reduced level, retry with timed off/on bursts up to a cap, or stay off until cleared. A two-bit clear policy selects what ends a reduced-level episode and whether a thermal episode also needs the strobe. Thermal shutdown can pre-empt any over-current response. Every episode passes through a recover state in which the switch is on at full level until the bus reports healthy. The block counts fault entries and reports how many cycles each episode kept the block away from normal operation.

Top module: `hsw_fault_ctrl`

## Requirements
- R1: After reset, `sw_en`=1, `ilim_low`=0, `lockout`=0, both fault bits are 0 and both event counters are 0.
- R2: An over-current is declared only after `oc_flag` is sampled high on `cfg_qual` consecutive clock edges (0 behaves as 1) while in normal or recover operation; a shorter burst changes no output.
- R3: On the edge that declares an over-current, the block enters a one-cycle latch state with `sw_en`=0, `ilim_low`=0 and `oc_fault`=1, before any profile action.
- R4: With `cfg_profile`=0 (reduced level), the latch state is followed by `sw_en`=1 and `ilim_low`=1 until the clear condition of R8 holds, then the recover state.
- R5: With `cfg_profile`=1 (retry), the switch is off for `cfg_retry_period` cycles, then on for up to `cfg_retry_period` cycles; `oc_flag` high during an on-phase returns it to off, and an on-phase that completes leads to the recover state.
- R6: In retry mode, once `cfg_retry_max` on-phases have been spent and another off-phase ends, `lockout`=1 and `sw_en`=0 until `clr_strobe`, even with `bus_ok`=1 and `oc_flag`=0.
- R7: With `cfg_profile`=2 or 3 (latched), the latch state is followed by `lockout`=1 and `sw_en`=0 until `clr_strobe`, whatever `bus_ok` does.
- R8: `cfg_clr` ends a reduced-level episode: 0 after `cfg_clr_time` cycles in it (0 behaves as 1), 1 when `bus_ok`=1, 2 when `ot_flag`=0, 3 on `clr_strobe`.
- R9: `ot_flag` sampled high in any state gives `sw_en`=0 and `ot_fault`=1 the next cycle; thermal shutdown ends when `ot_flag`=0 and, only when `cfg_clr`=3, `clr_strobe`=1 on the same edge.
- R10: When the thermal flag and a qualified over-current arrive on the same edge, thermal shutdown is entered, `oc_fault` stays 0 and `oc_cnt` does not change.
- R11: In the recover state `sw_en`=1 and `ilim_low`=0 with the fault bits still set; the first `bus_ok`=1 returns to normal and clears both fault bits.
- R12: `oc_cnt` and `ot_cnt` each increase by one per entry into their fault state, not per cycle spent there, and hold at all-ones.
- R13: On return to normal, `rec_done` pulses for one cycle with `rec_time` equal to the cycles spent outside normal operation since detection; beyond all-ones it holds all-ones and `rec_ovf`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oc_flag | input | 1 | Over-current comparator flag |
| ot_flag | input | 1 | Over-temperature flag with hysteresis |
| bus_ok | input | 1 | Bus healthy / short removed |
| clr_strobe | input | 1 | Register clear strobe |
| cfg_profile | input | 2 | 0 reduced level, 1 retry, 2/3 latched |
| cfg_clr | input | 2 | Clear policy: 0 time, 1 bus, 2 temperature, 3 strobe |
| cfg_qual | input | QUAL_W | Over-current qualification cycles |
| cfg_retry_period | input | TMR_W | Retry off and on phase length |
| cfg_clr_time | input | TMR_W | Timed clear length |
| cfg_retry_max | input | RTRY_W | Maximum retry on-phases |
| sw_en | output | 1 | Switch enable |
| ilim_low | output | 1 | Reduced current level select |
| lockout | output | 1 | Held off until clear strobe |
| oc_fault | output | 1 | Over-current fault bit |
| ot_fault | output | 1 | Thermal fault bit |
| oc_cnt | output | CNT_W | Saturating over-current entry count |
| ot_cnt | output | CNT_W | Saturating thermal entry count |
| rec_time | output | MEAS_W | Last measured recovery time in cycles |
| rec_ovf | output | 1 | Recovery time exceeded its range |
| rec_done | output | 1 | One-cycle pulse when a recovery ends |

## Verification
A wrong state shows at the enable within one cycle: the bench samples `sw_en`, `ilim_low` and `lockout` at each edge of every scripted episode, so an off-phase that is one cycle short or long, or a missing latch cycle, is seen the cycle it happens. A wrong retry count or a lost timer shows as a different number of on-cycles or a lockout at the wrong edge. Errors in the episode timer appear only at the end of an episode, when the measured time is popped against the cycle count worked out for that script, and counters that count per cycle instead of per entry are caught by reading them during long fault holds.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL,
        ST_OC_LATCH,
        ST_REDUCED,
        ST_RETRY_OFF,
        ST_RETRY_ON,
        ST_HOLD_OFF,
        ST_THERMAL,
        ST_RECOVER
    } hsw_state_e;

    localparam logic [1:0] PROF_REDUCED = 2'd0;
    localparam logic [1:0] PROF_RETRY   = 2'd1;

    localparam logic [1:0] CLR_TIME = 2'd0;
    localparam logic [1:0] CLR_BUS  = 2'd1;
    localparam logic [1:0] CLR_TEMP = 2'd2;
    localparam logic [1:0] CLR_REG  = 2'd3;

endpackage

// File: rtl/hsw_oc_qual.sv
module hsw_oc_qual #(
    parameter int QUAL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              oc_flag,
    input  logic [QUAL_W-1:0] cfg_qual,
    output logic              oc_det
);
    localparam int EXT_W = QUAL_W + 1;

    logic [QUAL_W-1:0] run_d, run_q;
    logic [EXT_W-1:0]  need;
    logic [EXT_W-1:0]  seen;

    always_comb begin
        need = (cfg_qual == '0) ? EXT_W'(1) : {1'b0, cfg_qual};
        seen = {1'b0, run_q} + EXT_W'(1);
        oc_det = arm && oc_flag && (seen >= need);
        if (!arm || !oc_flag) begin
            run_d = '0;
        end else if (&run_q) begin
            run_d = run_q;
        end else begin
            run_d = run_q + QUAL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end
endmodule

// File: rtl/hsw_sat_cnt.sv
module hsw_sat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] val
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (inc && !(&val_q)) val_d = val_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign val = val_q;
endmodule

// File: rtl/hsw_fault_ctrl.sv
module hsw_fault_ctrl
    import hsw_pkg::*;
#(
    parameter int QUAL_W = 8,
    parameter int TMR_W  = 16,
    parameter int RTRY_W = 4,
    parameter int CNT_W  = 8,
    parameter int MEAS_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oc_flag,
    input  logic              ot_flag,
    input  logic              bus_ok,
    input  logic              clr_strobe,
    input  logic [1:0]        cfg_profile,
    input  logic [1:0]        cfg_clr,
    input  logic [QUAL_W-1:0] cfg_qual,
    input  logic [TMR_W-1:0]  cfg_retry_period,
    input  logic [TMR_W-1:0]  cfg_clr_time,
    input  logic [RTRY_W-1:0] cfg_retry_max,
    output logic              sw_en,
    output logic              ilim_low,
    output logic              lockout,
    output logic              oc_fault,
    output logic              ot_fault,
    output logic [CNT_W-1:0]  oc_cnt,
    output logic [CNT_W-1:0]  ot_cnt,
    output logic [MEAS_W-1:0] rec_time,
    output logic              rec_ovf,
    output logic              rec_done
);
    localparam int TX_W    = TMR_W + 1;
    localparam int N_EVENT = 2;

    typedef struct packed {
        hsw_state_e        st;
        logic [TMR_W-1:0]  tmr;
        logic [RTRY_W-1:0] rtry;
        logic [MEAS_W-1:0] run;
        logic              run_ovf;
        logic [MEAS_W-1:0] meas;
        logic              meas_ovf;
        logic              done;
        logic              oc_flt;
        logic              ot_flt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             oc_det;
    logic             armed;
    logic [TX_W-1:0]  tmr_nx;
    logic             per_done;
    logic             clr_done;
    logic             clr_ok;
    hsw_state_e       nxt;
    logic [N_EVENT-1:0]  ev;
    logic [CNT_W-1:0]    cnt_arr [N_EVENT];

    assign armed = (ctl_q.st == ST_NORMAL) || (ctl_q.st == ST_RECOVER);

    hsw_oc_qual #(.QUAL_W(QUAL_W)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (armed),
        .oc_flag  (oc_flag),
        .cfg_qual (cfg_qual),
        .oc_det   (oc_det)
    );

    always_comb begin
        tmr_nx   = {1'b0, ctl_q.tmr} + TX_W'(1);
        per_done = tmr_nx >= {1'b0, cfg_retry_period};
        clr_done = tmr_nx >= {1'b0, cfg_clr_time};
        unique case (cfg_clr)
            CLR_TIME: clr_ok = clr_done;
            CLR_BUS:  clr_ok = bus_ok;
            CLR_TEMP: clr_ok = !ot_flag;
            default:  clr_ok = clr_strobe;
        endcase
    end

    always_comb begin
        nxt = ctl_q.st;
        unique case (ctl_q.st)
            ST_NORMAL: begin
                if (ot_flag)     nxt = ST_THERMAL;
                else if (oc_det) nxt = ST_OC_LATCH;
            end
            ST_OC_LATCH: begin
                if (ot_flag)                          nxt = ST_THERMAL;
                else if (cfg_profile == PROF_REDUCED) nxt = ST_REDUCED;
                else if (cfg_profile == PROF_RETRY)   nxt = ST_RETRY_OFF;
                else                                  nxt = ST_HOLD_OFF;
            end
            ST_REDUCED: begin
                if (ot_flag)     nxt = ST_THERMAL;
                else if (clr_ok) nxt = ST_RECOVER;
            end
            ST_RETRY_OFF: begin
                if (ot_flag) begin
                    nxt = ST_THERMAL;
                end else if (per_done) begin
                    nxt = (ctl_q.rtry == cfg_retry_max) ? ST_HOLD_OFF : ST_RETRY_ON;
                end
            end
            ST_RETRY_ON: begin
                if (ot_flag)       nxt = ST_THERMAL;
                else if (oc_flag)  nxt = ST_RETRY_OFF;
                else if (per_done) nxt = ST_RECOVER;
            end
            ST_HOLD_OFF: begin
                if (ot_flag)         nxt = ST_THERMAL;
                else if (clr_strobe) nxt = ST_RECOVER;
            end
            ST_THERMAL: begin
                if (!ot_flag && (cfg_clr != CLR_REG || clr_strobe)) nxt = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (ot_flag)     nxt = ST_THERMAL;
                else if (oc_det) nxt = ST_OC_LATCH;
                else if (bus_ok) nxt = ST_NORMAL;
            end
            default: nxt = ST_NORMAL;
        endcase
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.st   = nxt;
        ctl_d.done = 1'b0;

        ev[0] = (nxt == ST_OC_LATCH);
        ev[1] = (nxt == ST_THERMAL) && (ctl_q.st != ST_THERMAL);

        if (nxt != ctl_q.st)  ctl_d.tmr = '0;
        else if (!(&ctl_q.tmr)) ctl_d.tmr = ctl_q.tmr + TMR_W'(1);

        if (ev[0]) ctl_d.rtry = '0;
        else if (ctl_q.st == ST_RETRY_OFF && nxt == ST_RETRY_ON)
            ctl_d.rtry = ctl_q.rtry + RTRY_W'(1);

        if (ev[0]) ctl_d.oc_flt = 1'b1;
        if (ev[1]) ctl_d.ot_flt = 1'b1;

        if (ctl_q.st == ST_NORMAL) begin
            ctl_d.run     = '0;
            ctl_d.run_ovf = 1'b0;
        end else begin
            ctl_d.run     = (&ctl_q.run) ? ctl_q.run : ctl_q.run + MEAS_W'(1);
            ctl_d.run_ovf = ctl_q.run_ovf | (&ctl_q.run);
        end

        if (ctl_q.st != ST_NORMAL && nxt == ST_NORMAL) begin
            ctl_d.meas     = ctl_d.run;
            ctl_d.meas_ovf = ctl_d.run_ovf;
            ctl_d.done     = 1'b1;
            ctl_d.oc_flt   = 1'b0;
            ctl_d.ot_flt   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_NORMAL, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar gi = 0; gi < N_EVENT; gi++) begin : g_evcnt
        hsw_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (ev[gi]),
            .val   (cnt_arr[gi])
        );
    end

    assign oc_cnt = cnt_arr[0];
    assign ot_cnt = cnt_arr[1];

    assign sw_en    = (ctl_q.st == ST_NORMAL) || (ctl_q.st == ST_REDUCED)
                   || (ctl_q.st == ST_RETRY_ON) || (ctl_q.st == ST_RECOVER);
    assign ilim_low = (ctl_q.st == ST_REDUCED);
    assign lockout  = (ctl_q.st == ST_HOLD_OFF);
    assign oc_fault = ctl_q.oc_flt;
    assign ot_fault = ctl_q.ot_flt;
    assign rec_time = ctl_q.meas;
    assign rec_ovf  = ctl_q.meas_ovf;
    assign rec_done = ctl_q.done;
endmodule

// File: rtl/hsw_fault_ctrl_chk.sv
module hsw_fault_ctrl_chk #(
    parameter int CNT_W  = 8,
    parameter int MEAS_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ot_flag,
    input logic              sw_en,
    input logic              ilim_low,
    input logic              lockout,
    input logic              oc_fault,
    input logic [CNT_W-1:0]  oc_cnt,
    input logic [CNT_W-1:0]  ot_cnt,
    input logic [MEAS_W-1:0] rec_time,
    input logic              rec_ovf,
    input logic              rec_done
);
    // R3
    latch_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oc_fault) |-> !sw_en);

    // R4
    reduced_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ilim_low |-> sw_en);

    // R6
    lockout_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |-> !sw_en && !ilim_low);

    // R9
    thermal_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ot_flag |=> !sw_en);

    // R10
    thermal_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ot_flag |=> !$rose(oc_fault));

    // R11
    done_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |-> sw_en && !ilim_low && !lockout);

    // R12
    oc_cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_cnt == $past(oc_cnt)) || (oc_cnt == $past(oc_cnt) + CNT_W'(1)));

    // R12
    ot_cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_cnt == $past(ot_cnt)) || (ot_cnt == $past(ot_cnt) + CNT_W'(1)));

    // R13
    rec_ovf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_ovf |-> &rec_time);

    // R13
    rec_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_done |-> $stable(rec_time));
endmodule

bind hsw_fault_ctrl hsw_fault_ctrl_chk #(.CNT_W(CNT_W), .MEAS_W(MEAS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ot_flag  (ot_flag),
    .sw_en    (sw_en),
    .ilim_low (ilim_low),
    .lockout  (lockout),
    .oc_fault (oc_fault),
    .oc_cnt   (oc_cnt),
    .ot_cnt   (ot_cnt),
    .rec_time (rec_time),
    .rec_ovf  (rec_ovf),
    .rec_done (rec_done)
);

// File: tb/hsw_fault_ctrl_tb.sv
module hsw_fault_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W  = 3;
    localparam int MEAS_W = 6;
    localparam int OVF_BIT = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oc_flag = 1'b0, ot_flag = 1'b0, bus_ok = 1'b1, clr_strobe = 1'b0;
    logic [1:0]  cfg_profile = 2'd0;
    logic [1:0]  cfg_clr = 2'd1;
    logic [7:0]  cfg_qual = 8'd3;
    logic [15:0] cfg_retry_period = 16'd4;
    logic [15:0] cfg_clr_time = 16'd5;
    logic [3:0]  cfg_retry_max = 4'd2;
    logic sw_en, ilim_low, lockout, oc_fault, ot_fault, rec_ovf, rec_done;
    logic [CNT_W-1:0]  oc_cnt, ot_cnt;
    logic [MEAS_W-1:0] rec_time;

    int checks = 0;
    int errors = 0;
    int exp_oc = 0;
    int exp_ot = 0;
    int rec_q[$];
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hsw_fault_ctrl #(.CNT_W(CNT_W), .MEAS_W(MEAS_W)) u_dut (
        .clk, .rst_n, .oc_flag, .ot_flag, .bus_ok, .clr_strobe,
        .cfg_profile, .cfg_clr, .cfg_qual, .cfg_retry_period, .cfg_clr_time,
        .cfg_retry_max, .sw_en, .ilim_low, .lockout, .oc_fault, .ot_fault,
        .oc_cnt, .ot_cnt, .rec_time, .rec_ovf, .rec_done
    );

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sat(int v);
        return (v > (1 << CNT_W) - 1) ? (1 << CNT_W) - 1 : v;
    endfunction

    task automatic expect_rec(int cycles);
        int m = (1 << MEAS_W) - 1;
        if (cycles > m) rec_q.push_back((1 << OVF_BIT) | m);
        else            rec_q.push_back(cycles);
    endtask

    // scoreboard monitor: R13
    always @(negedge clk) begin
        if (rst_n && rec_done) begin
            int got;
            got = (int'(rec_ovf) << OVF_BIT) | int'(rec_time);
            checks++;
            if (rec_q.size() == 0) begin
                errors++;
                $display("FAIL R13 unexpected recovery: actual %0d expected none", got);
            end else begin
                int exp;
                exp = rec_q.pop_front();
                if (got != exp) begin
                    errors++;
                    $display("FAIL R13 recovery time: actual %0d expected %0d", got, exp);
                end
            end
        end
    end

    // qualify an over-current: detection edge has passed on return
    task automatic qualify_oc();
        oc_flag = 1'b1;
        tick(3);
        exp_oc++;
    endtask

    task automatic thermal_pulse();
        expect_rec(2);
        ot_flag = 1'b1; tick(); exp_ot++;
        ot_flag = 1'b0; tick();
        tick();
    endtask

    initial begin
        int on_cycles;
        tick(3);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1", "sw_en", sw_en, 1);
        chk("R1", "ilim_low", ilim_low, 0);
        chk("R1", "lockout", lockout, 0);
        chk("R1", "faults", {oc_fault, ot_fault}, 0);
        chk("R1", "counters", oc_cnt + ot_cnt, 0);

        // R2 short burst ignored
        oc_flag = 1'b1; tick(2);
        oc_flag = 1'b0; tick();
        chk("R2", "burst sw_en", sw_en, 1);
        chk("R2", "burst oc_fault", oc_fault, 0);
        chk("R2", "burst oc_cnt", oc_cnt, 0);

        // R4 reduced level, bus clear policy
        cfg_profile = 2'd0; cfg_clr = 2'd1; bus_ok = 1'b0;
        expect_rec(6);
        qualify_oc();
        chk("R3", "latch sw_en", sw_en, 0);
        chk("R3", "latch oc_fault", oc_fault, 1);
        chk("R3", "latch ilim_low", ilim_low, 0);
        chk("R12", "oc_cnt entry", oc_cnt, sat(exp_oc));
        tick();
        chk("R4", "reduced sw_en", sw_en, 1);
        chk("R4", "reduced ilim_low", ilim_low, 1);
        tick(3);
        chk("R4", "held ilim_low", ilim_low, 1);
        chk("R12", "oc_cnt per entry", oc_cnt, sat(exp_oc));
        oc_flag = 1'b0; bus_ok = 1'b1; tick();
        chk("R11", "recover sw_en", sw_en, 1);
        chk("R11", "recover ilim_low", ilim_low, 0);
        chk("R11", "recover oc_fault", oc_fault, 1);
        tick();
        chk("R11", "normal oc_fault", oc_fault, 0);

        // R5 retry succeeds
        cfg_profile = 2'd1;
        expect_rec(10);
        qualify_oc();
        tick();
        chk("R5", "off phase sw_en", sw_en, 0);
        oc_flag = 1'b0;
        tick(3);
        chk("R5", "off phase end sw_en", sw_en, 0);
        tick();
        chk("R5", "on phase sw_en", sw_en, 1);
        tick(3);
        chk("R5", "on phase last sw_en", sw_en, 1);
        tick();
        chk("R5", "recover oc_fault", oc_fault, 1);
        tick();
        chk("R5", "normal oc_fault", oc_fault, 0);

        // R6 retry cap and lockout
        expect_rec(22);
        qualify_oc();
        on_cycles = 0;
        for (int i = 0; i < 15; i++) begin
            tick();
            if (sw_en) on_cycles++;
        end
        chk("R6", "retry on-cycles", on_cycles, 2);
        chk("R6", "lockout", lockout, 1);
        oc_flag = 1'b0; bus_ok = 1'b1;
        tick(5);
        chk("R6", "lockout after short gone sw_en", sw_en, 0);
        chk("R6", "lockout held", lockout, 1);
        clr_strobe = 1'b1; tick();
        clr_strobe = 1'b0;
        chk("R6", "released sw_en", sw_en, 1);
        tick();

        // R7 latched profile
        cfg_profile = 2'd2;
        expect_rec(7);
        qualify_oc();
        tick();
        chk("R7", "latched lockout", lockout, 1);
        oc_flag = 1'b0;
        tick(4);
        chk("R7", "latched sw_en", sw_en, 0);
        clr_strobe = 1'b1; tick();
        clr_strobe = 1'b0;
        chk("R7", "released sw_en", sw_en, 1);
        tick();

        // R8 timed clear
        cfg_profile = 2'd0; cfg_clr = 2'd0;
        expect_rec(7);
        qualify_oc();
        oc_flag = 1'b0;
        tick(5);
        chk("R8", "timed last ilim_low", ilim_low, 1);
        tick();
        chk("R8", "timed ended ilim_low", ilim_low, 0);
        tick();

        // R8 strobe clear
        cfg_clr = 2'd3;
        expect_rec(6);
        qualify_oc();
        tick();
        oc_flag = 1'b0;
        tick(3);
        chk("R8", "strobe wait ilim_low", ilim_low, 1);
        clr_strobe = 1'b1; tick();
        clr_strobe = 1'b0;
        chk("R8", "strobe ended ilim_low", ilim_low, 0);
        tick();

        // R9 thermal, bus policy
        cfg_clr = 2'd1;
        expect_rec(5);
        ot_flag = 1'b1; tick(); exp_ot++;
        chk("R9", "thermal sw_en", sw_en, 0);
        chk("R9", "ot_fault", ot_fault, 1);
        chk("R12", "ot_cnt entry", ot_cnt, sat(exp_ot));
        tick(3);
        chk("R12", "ot_cnt per entry", ot_cnt, sat(exp_ot));
        ot_flag = 1'b0; tick();
        chk("R9", "thermal exit sw_en", sw_en, 1);
        tick();
        chk("R11", "thermal normal ot_fault", ot_fault, 0);

        // R9 thermal, strobe policy
        cfg_clr = 2'd3;
        expect_rec(5);
        ot_flag = 1'b1; tick(); exp_ot++;
        ot_flag = 1'b0;
        tick(3);
        chk("R9", "thermal waits strobe", sw_en, 0);
        clr_strobe = 1'b1; tick();
        clr_strobe = 1'b0;
        chk("R9", "thermal strobe exit", sw_en, 1);
        tick();

        // R10 thermal wins
        cfg_clr = 2'd1;
        expect_rec(2);
        oc_flag = 1'b1; tick(2);
        ot_flag = 1'b1; tick(); exp_ot++;
        chk("R10", "oc_fault", oc_fault, 0);
        chk("R10", "oc_cnt", oc_cnt, sat(exp_oc));
        chk("R10", "ot_cnt", ot_cnt, sat(exp_ot));
        oc_flag = 1'b0; ot_flag = 1'b0; tick();
        tick();

        // R13 overflow
        expect_rec(71);
        ot_flag = 1'b1; tick(); exp_ot++;
        tick(69);
        ot_flag = 1'b0; tick();
        tick();

        // R12 saturation
        for (int i = 0; i < 5; i++) thermal_pulse();
        chk("R12", "ot_cnt saturated", ot_cnt, sat(exp_ot));
        chk("R12", "oc_cnt final", oc_cnt, sat(exp_oc));

        tick(2);
        chk("R13", "pending recoveries", rec_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule